// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block keeps track of which operating mode a CAN controller is in: sleep, initialization or normal. Software asks for initialization or sleep by holding a request level, and the block answers with a matching acknowledge flag once that mode has actually been reached. Request and acknowledge are separate handshakes, so software polls the acknowledge rather than assuming the request took effect.

Leaving initialization or sleep toward normal operation is not immediate. The block first waits until the bus has been idle. Idle means a run of `SYNC_BITS` (default 11) consecutive recessive bits, each sampled on a bit-time strobe. A dominant bit anywhere in the run starts the count over. While it waits, both acknowledge flags are low and a busy-sync status is high.

After reset the block sits in sleep with the transmit-pin pull-up enabled. The pull-up stays on only until the block first leaves that reset sleep state. All inputs and outputs are plain control and status levels, with no stream handshake.

Top module: `can_mode_seq`

## Requirements
- R1: While `rst_n` is low and on every cycle after reset until a request changes the mode, `sleep_ack`=1, `tx_pullup_en`=1, and `init_ack`=`busy_sync`=`normal_mode`=0.
- R2: Exactly one of `init_ack`, `sleep_ack`, `busy_sync` and `normal_mode` is high in every cycle.
- R3: If `init_req`=1 at a clock edge, `init_ack` is 1 after that edge, from any mode and whatever `sleep_req` is (initialization has priority).
- R4: If `sleep_req`=1 and `init_req`=0 at a clock edge, `sleep_ack` is 1 after that edge, from any mode.
- R5: If both requests are 0 at an edge while in sleep or initialization, the acknowledge drops and `busy_sync` is 1 after that edge. The block does not go to normal directly.
- R6: In busy-sync with both requests 0, `normal_mode` becomes 1 after the edge that samples the `SYNC_BITS`-th consecutive strobe with `rx_bit`=1 (1 = recessive). `normal_mode` is entered from no mode other than busy-sync.
- R7: A strobe with `rx_bit`=0 (dominant) during busy-sync restarts the recessive count from zero.
- R8: `rx_bit` is ignored on cycles where `bit_tick`=0, so a dominant level without a strobe does not restart the count.
- R9: `tx_pullup_en` falls at the first edge that leaves the reset sleep state and never rises again before the next reset. A later sleep entered by request keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Software request for initialization mode |
| sleep_req | input | 1 | Software request for sleep mode |
| rx_bit | input | 1 | Received bus level, 1 = recessive, 0 = dominant |
| bit_tick | input | 1 | One-cycle strobe marking the bit sample point |
| init_ack | output | 1 | Initialization mode reached |
| sleep_ack | output | 1 | Sleep mode reached |
| busy_sync | output | 1 | Waiting for an idle bus before normal mode |
| normal_mode | output | 1 | Normal operation |
| tx_pullup_en | output | 1 | Transmit-pin pull-up enable |

## Verification
A clock-by-clock reference model is driven with four kinds of input pattern:
- Both requests raised together, which tells initialization priority apart from a sleep-first order.
- An uninterrupted recessive run, which pins the exact cycle that normal mode starts.
- A run broken by one dominant strobe, which separates a restarting counter from one that only pauses or keeps counting.
- Dominant levels held between strobes, which show whether non-strobe cycles are really ignored.

A long stretch of random requests, levels and strobes then checks the one-status-high rule and the one-way pull-up across mode paths the directed phases do not reach.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_NORMAL = 2'd3
  } can_mode_e;

endpackage

// File: rtl/can_sync_detect.sv
module can_sync_detect #(
  parameter int unsigned SYNC_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_clear,
  input  logic bit_tick,
  input  logic rx_bit,
  output logic sync_done
);
  localparam int unsigned CW = $clog2(SYNC_BITS + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(SYNC_BITS);
  localparam logic [CW-1:0] RUN_LAST = CW'(SYNC_BITS - 1);

  logic [CW-1:0] run_q;

  // run length of recessive strobes; cleared outside the sync wait
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (hold_clear) begin
      run_q <= '0;
    end else if (bit_tick) begin
      if (!rx_bit) begin
        run_q <= '0;
      end else if (run_q != RUN_MAX) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign sync_done = !hold_clear && bit_tick && rx_bit && (run_q == RUN_LAST);

  a_r7_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clear && bit_tick && !rx_bit) |=> (run_q == '0));

  a_r8_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clear && !bit_tick) |=> $stable(run_q));

  a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      init_req,
  input  logic      sleep_req,
  input  logic      sync_done,
  output can_mode_e mode_q,
  output logic      pull_q
);
  can_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (init_req) begin
      mode_d = MODE_INIT;
    end else if (sleep_req) begin
      mode_d = MODE_SLEEP;
    end else begin
      case (mode_q)
        MODE_SLEEP:  mode_d = MODE_SYNC;
        MODE_INIT:   mode_d = MODE_SYNC;
        MODE_SYNC:   mode_d = sync_done ? MODE_NORMAL : MODE_SYNC;
        MODE_NORMAL: mode_d = MODE_NORMAL;
        default:     mode_d = MODE_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SLEEP;
      pull_q <= 1'b1;
    end else begin
      mode_q <= mode_d;
      pull_q <= pull_q && (mode_d == MODE_SLEEP);
    end
  end

  a_r9_pullup_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> (mode_q == MODE_SLEEP));

  a_r9_pullup_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pull_q));

  a_r6_sync_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SYNC && sync_done && !init_req && !sleep_req) |=> (mode_q == MODE_NORMAL));

  a_r5_release_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_INIT || mode_q == MODE_SLEEP) && !init_req && !sleep_req) |=> (mode_q == MODE_SYNC));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int unsigned SYNC_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic sleep_req,
  input  logic rx_bit,
  input  logic bit_tick,
  output logic init_ack,
  output logic sleep_ack,
  output logic busy_sync,
  output logic normal_mode,
  output logic tx_pullup_en
);
  can_mode_e mode_q;
  logic      pull_q;
  logic      sync_done;
  logic      not_syncing;

  assign not_syncing = (mode_q != MODE_SYNC);

  can_sync_detect #(.SYNC_BITS(SYNC_BITS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_clear(not_syncing),
    .bit_tick  (bit_tick),
    .rx_bit    (rx_bit),
    .sync_done (sync_done)
  );

  can_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .sleep_req(sleep_req),
    .sync_done(sync_done),
    .mode_q   (mode_q),
    .pull_q   (pull_q)
  );

  assign init_ack     = (mode_q == MODE_INIT);
  assign sleep_ack    = (mode_q == MODE_SLEEP);
  assign busy_sync    = (mode_q == MODE_SYNC);
  assign normal_mode  = (mode_q == MODE_NORMAL);
  assign tx_pullup_en = pull_q;

  a_r2_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({init_ack, sleep_ack, busy_sync, normal_mode}) == 1);

  a_r3_init_priority: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> init_ack);

  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !init_req) |=> (sleep_ack && !tx_pullup_en || sleep_ack && $past(tx_pullup_en)));

  a_r6_normal_via_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(normal_mode) |-> $past(busy_sync));

endmodule

// File: tb/can_mode_seq_bench.sv
module can_mode_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, sleep_req = 1'b1, rx_bit = 1'b1, bit_tick = 1'b0;
  logic init_ack, sleep_ack, busy_sync, normal_mode, tx_pullup_en;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  // behavioural reference: 0 sleep, 1 init, 2 sync, 3 normal
  int m_mode = 0, m_run = 0;
  bit m_pull = 1'b1;

  always #10 clk = ~clk;

  can_mode_seq u_can_mode_seq (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .sleep_req(sleep_req),
    .rx_bit(rx_bit), .bit_tick(bit_tick), .init_ack(init_ack), .sleep_ack(sleep_ack),
    .busy_sync(busy_sync), .normal_mode(normal_mode), .tx_pullup_en(tx_pullup_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_pull = 1'b1;
    end else begin
      int nxt;
      nxt = m_mode;
      if (init_req) nxt = 1;
      else if (sleep_req) nxt = 0;
      else if (m_mode == 0 || m_mode == 1) nxt = 2;
      else if (m_mode == 2 && bit_tick) begin
        if (rx_bit) begin
          m_run = m_run + 1;
          if (m_run >= 11) nxt = 3;
        end else m_run = 0;
      end
      if (nxt != 2) m_run = 0;
      if (nxt != 0) m_pull = 1'b0;
      m_mode = nxt;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string name);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", cur_tag, name, act, exp, cycles);
    end
  endtask

  task automatic compare();
    chk(init_ack, m_mode == 1, "init_ack");
    chk(sleep_ack, m_mode == 0, "sleep_ack");
    chk(busy_sync, m_mode == 2, "busy_sync");
    chk(normal_mode, m_mode == 3, "normal_mode");
    chk(tx_pullup_en, m_pull, "tx_pullup_en");
  endtask

  // compare at the falling edge, then drive the next inputs
  task automatic step(input logic ir, input logic sr, input logic rx, input logic tk);
    @(negedge clk);
    compare();
    init_req = ir; sleep_req = sr; rx_bit = rx; bit_tick = tk;
  endtask

  task automatic bits(input int n, input logic val);
    for (int i = 0; i < n; i++) begin
      step(0, 0, val, 1);
      step(0, 0, 1'b0, 0);   // R8: dominant level without strobe
      step(0, 0, 1'b1, 0);
    end
  endtask

  initial begin
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    repeat (4) step(0, 1, 1, 0);

    cur_tag = "R3";
    step(1, 1, 1, 0);
    repeat (3) step(1, 1, 1, 0);

    cur_tag = "R5";
    repeat (3) step(0, 0, 1, 0);

    cur_tag = "R7";
    bits(5, 1'b1);
    bits(1, 1'b0);
    cur_tag = "R8";
    bits(4, 1'b1);
    cur_tag = "R6";
    bits(8, 1'b1);
    repeat (3) step(0, 0, 1, 0);

    cur_tag = "R4";
    repeat (3) step(0, 1, 1, 0);
    cur_tag = "R9";
    repeat (3) step(0, 1, 0, 1);

    cur_tag = "R3";
    repeat (3) step(0, 0, 1, 1);
    repeat (3) step(1, 0, 1, 1);

    cur_tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic ir, sr, rx, tk;
      ir = ($urandom_range(0, 15) == 0);
      sr = ($urandom_range(0, 15) == 0);
      rx = ($urandom_range(0, 9) != 0);
      tk = ($urandom_range(0, 2) == 0);
      step(ir, sr, rx, tk);
    end
    step(0, 0, 1, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule